// File: doc/BRIEF.md
# Multi-mode operand address generator

This block forms the memory address of an instruction operand for a CISC-style addressing scheme. On a start strobe it captures the addressing mode, the selected address register value, the program counter, an index register, a scale code, a base displacement, an outer displacement and the operand size. It then produces the final operand address and, for the auto-modifying modes, the new address register value to write back.

Register-based modes finish in a single cycle. The two memory-indirect modes first fetch a pointer through a simple request/acknowledge read port, so they take extra cycles. During that time the block holds a busy flag and ignores new start strobes. Instruction decoding and the data cache sit outside the block.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode code 0 (register indirect) yields the address register value as the address, with `wb_en` low. For every mode other than 6 and 7, `done` pulses high in the cycle after the clock edge that samples `start`.
- R2: Mode code 3 (displacement) yields base + sign-extended `disp_in[15:0]`.
- R3: Mode code 4 (short indexed) yields base + sign-extended `disp_in[7:0]` + index × scale. The `idx_scale` codes 0, 1, 2 and 3 select ×1, ×2, ×4 and ×8.
- R4: Mode code 5 (full indexed) yields base + displacement + index × scale. The displacement is the full 32-bit `disp_in` when `disp_long`=1, and sign-extended `disp_in[15:0]` when `disp_long`=0.
- R5: When `use_pc`=1, `pc_val` replaces the address register as the base in modes 3 to 7. In modes 0 to 2, `use_pc` has no effect.
- R6: Mode code 1 (pre-decrement) yields base − step as both the address and `wb_val`, with `wb_en` high. The step is 1, 2 or 4 for `op_size` codes 0 (byte), 1 (word) and 2 (long).
- R7: Mode code 2 (post-increment) yields base as the address and base + step as `wb_val`, with `wb_en` high.
- R8: When `reg_is_sp`=1 and `op_size`=0, the auto-modify step is 2 instead of 1.
- R9: Mode code 6 (memory-indirect, pre-indexed) reads a pointer at base + displacement + index × scale, using the displacement rule of R4. The final address is pointer + `outer_disp`, and `wb_en` stays low.
- R10: Mode code 7 (memory-indirect, post-indexed) reads a pointer at base + displacement, using the displacement rule of R4. The final address is pointer + index × scale + `outer_disp`.
- R11: In modes 6 and 7, `busy` and `ptr_req` rise in the cycle after start. `ptr_req` and `ptr_addr` stay stable until `ptr_ack`. `done` pulses in the cycle after the acknowledge, and `busy` falls at the same time. A start strobe that arrives while `busy` is high is ignored.
- R12: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation with the current inputs |
| mode | input | 3 | Addressing mode code (0 to 7) |
| use_pc | input | 1 | Use the program counter as the base |
| reg_is_sp | input | 1 | The selected address register is the stack pointer |
| base_reg | input | 32 | Selected address register value |
| pc_val | input | 32 | Program counter value |
| idx_val | input | 32 | Index register value |
| idx_scale | input | 2 | Index scale code |
| disp_in | input | 32 | Base displacement |
| disp_long | input | 1 | Full 32-bit displacement in modes 5 to 7 |
| outer_disp | input | 32 | Outer displacement for the memory-indirect modes |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | One-cycle strobe: `addr_out` is valid |
| addr_out | output | 32 | Final operand address |
| wb_en | output | 1 | Write back `wb_val` to the address register, qualified by `done` |
| wb_val | output | 32 | Updated address register value |
| ptr_req | output | 1 | Pointer read request |
| ptr_addr | output | 32 | Pointer read address |
| ptr_ack | input | 1 | Pointer read response valid |
| ptr_data | input | 32 | Pointer read data |

## Verification
The in-RTL properties watch the pointer-fetch protocol on every cycle. They check that the request holds with a stable address until it is acknowledged, that an acknowledge ends busy and produces done one cycle later, that a start strobe during busy changes nothing, and that register modes complete in one cycle. They also check that the auto-modify step is always a single legal power of two and that writeback never coincides with a pointer fetch. The actual arithmetic can only be shown by the bench's scenarios. These cover each mode's address value, the sign extension of short displacements, scale codes, program counter substitution, the stack-pointer byte step, wrap-around, and the pointer-plus-outer sums of both indirect orderings.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

   typedef enum logic [2:0] {
      AM_IND     = 3'd0,
      AM_PREDEC  = 3'd1,
      AM_POSTINC = 3'd2,
      AM_DISP    = 3'd3,
      AM_IDX_S   = 3'd4,
      AM_IDX_F   = 3'd5,
      AM_MEM_PRE = 3'd6,
      AM_MEM_PST = 3'd7
   } addr_mode_e;

   typedef enum logic [1:0] {
      DX_BYTE = 2'd0,
      DX_WORD = 2'd1,
      DX_FULL = 2'd2
   } disp_kind_e;

   function automatic logic mode_is_mem(input logic [2:0] m);
      return (m == AM_MEM_PRE) || (m == AM_MEM_PST);
   endfunction

   function automatic logic mode_allows_pc(input logic [2:0] m);
      return m >= AM_DISP;
   endfunction

endpackage

// File: rtl/oag_disp_ext.sv
module oag_disp_ext
   import opnd_addr_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] raw,
   input  disp_kind_e    kind,
   output logic [AW-1:0] ext
);
   localparam int PAD8  = AW - 8;
   localparam int PAD16 = AW - 16;

   generate
      if (AW < 16) begin : g_bad_width
         $error("oag_disp_ext: AW must be at least 16");
      end
   endgenerate

   logic [AW-1:0] ext8;
   logic [AW-1:0] ext16;

   generate
      if (AW == 16) begin : g_narrow
         assign ext16 = raw;
      end else begin : g_wide
         assign ext16 = {{PAD16{raw[15]}}, raw[15:0]};
      end
   endgenerate

   assign ext8 = {{PAD8{raw[7]}}, raw[7:0]};

   always_comb begin
      unique case (kind)
         DX_BYTE: ext = ext8;
         DX_WORD: ext = ext16;
         default: ext = raw;
      endcase
   end

endmodule

// File: rtl/oag_idx_scale.sv
module oag_idx_scale #(
   parameter int AW      = 32,
   parameter int SCALE_W = 2
) (
   input  logic [AW-1:0]      idx,
   input  logic [SCALE_W-1:0] scale,
   output logic [AW-1:0]      scaled
);
   localparam int NSCALE = 1 << SCALE_W;

   generate
      if (NSCALE > AW) begin : g_bad_scale
         $error("oag_idx_scale: scale range exceeds address width");
      end
   endgenerate

   logic [AW-1:0] cand [NSCALE];

   generate
      for (genvar s = 0; s < NSCALE; s++) begin : g_shift
         assign cand[s] = idx << s;
      end
   endgenerate

   assign scaled = cand[scale];

endmodule

// File: rtl/oag_step.sv
module oag_step #(
   parameter int SW       = 3,
   parameter bit SP_ALIGN = 1'b1
) (
   input  logic [1:0]    size,
   input  logic          is_sp,
   output logic [SW-1:0] step
);
   generate
      if (SW < 3) begin : g_bad_sw
         $error("oag_step: step width must hold the value 4");
      end
   endgenerate

   logic [SW-1:0] raw_step;

   always_comb begin
      unique case (size)
         2'd0:    raw_step = SW'(1);
         2'd1:    raw_step = SW'(2);
         default: raw_step = SW'(4);
      endcase
   end

   generate
      if (SP_ALIGN) begin : g_sp_align
         assign step = (is_sp && size == 2'd0) ? SW'(2) : raw_step;
      end else begin : g_plain
         assign step = raw_step;
      end
   endgenerate

   always_comb begin
      p_step_legal_r8 : assert ($countones(step) == 1)
         else $error("auto-modify step is not a single power of two");
   end

endmodule

// File: rtl/oag_seq.sv
module oag_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_mem,
   input  logic ack,
   output logic busy,
   output logic load,
   output logic finish,
   output logic done
);
   typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} seq_st_e;

   seq_st_e st;

   assign busy   = (st == ST_FETCH);
   assign load   = start && !busy;
   assign finish = busy && ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         done <= 1'b0;
      end else begin
         done <= (load && !is_mem) || finish;
         if (load && is_mem)
            st <= ST_FETCH;
         else if (finish)
            st <= ST_IDLE;
      end
   end

   p_fast_done_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      load && !is_mem |=> done && !busy);
   p_hold_busy_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && !ack |=> busy && !done);
   p_ack_ends_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && ack |=> !busy && done);
   p_mem_starts_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      load && is_mem |=> busy && !done);

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
   import opnd_addr_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SCALE_W  = 2,
   parameter bit SP_ALIGN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2:0]         mode,
   input  logic               use_pc,
   input  logic               reg_is_sp,
   input  logic [AW-1:0]      base_reg,
   input  logic [AW-1:0]      pc_val,
   input  logic [AW-1:0]      idx_val,
   input  logic [SCALE_W-1:0] idx_scale,
   input  logic [AW-1:0]      disp_in,
   input  logic               disp_long,
   input  logic [AW-1:0]      outer_disp,
   input  logic [1:0]         op_size,
   output logic               busy,
   output logic               done,
   output logic [AW-1:0]      addr_out,
   output logic               wb_en,
   output logic [AW-1:0]      wb_val,
   output logic               ptr_req,
   output logic [AW-1:0]      ptr_addr,
   input  logic               ptr_ack,
   input  logic [AW-1:0]      ptr_data
);
   localparam int SW = 3;

   generate
      if (AW < 16) begin : g_bad_aw
         $error("opnd_addr_gen: AW must be at least 16");
      end
   endgenerate

   addr_mode_e    am;
   logic          mem_mode;
   logic [AW-1:0] eff_base;
   disp_kind_e    dkind;
   logic [AW-1:0] disp_x;
   logic [AW-1:0] idx_x;
   logic [SW-1:0] step;
   logic [AW-1:0] step_x;
   logic [AW-1:0] sum_inner;
   logic [AW-1:0] sum_full;
   logic          load;
   logic          finish;
   logic          done_q;

   logic [AW-1:0] post_add_q;
   logic [AW-1:0] ptr_addr_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] wb_q;
   logic          wb_en_q;

   assign am       = addr_mode_e'(mode);
   assign mem_mode = mode_is_mem(mode);
   assign eff_base = (use_pc && mode_allows_pc(mode)) ? pc_val : base_reg;

   always_comb begin
      unique case (am)
         AM_IDX_S:                    dkind = DX_BYTE;
         AM_IDX_F, AM_MEM_PRE, AM_MEM_PST:
                                      dkind = disp_long ? DX_FULL : DX_WORD;
         default:                     dkind = DX_WORD;
      endcase
   end

   oag_disp_ext #(.AW(AW)) u_disp (
      .raw  (disp_in),
      .kind (dkind),
      .ext  (disp_x)
   );

   oag_idx_scale #(.AW(AW), .SCALE_W(SCALE_W)) u_scale (
      .idx    (idx_val),
      .scale  (idx_scale),
      .scaled (idx_x)
   );

   oag_step #(.SW(SW), .SP_ALIGN(SP_ALIGN)) u_step (
      .size  (op_size),
      .is_sp (reg_is_sp),
      .step  (step)
   );

   assign step_x    = AW'(step);
   assign sum_inner = eff_base + disp_x;
   assign sum_full  = sum_inner + idx_x;

   oag_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .is_mem (mem_mode),
      .ack    (ptr_ack),
      .busy   (busy),
      .load   (load),
      .finish (finish),
      .done   (done_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q     <= '0;
         wb_q       <= '0;
         wb_en_q    <= 1'b0;
         ptr_addr_q <= '0;
         post_add_q <= '0;
      end else begin
         wb_en_q <= 1'b0;
         if (load) begin
            unique case (am)
               AM_IND: begin
                  addr_q <= eff_base;
               end
               AM_PREDEC: begin
                  addr_q  <= eff_base - step_x;
                  wb_q    <= eff_base - step_x;
                  wb_en_q <= 1'b1;
               end
               AM_POSTINC: begin
                  addr_q  <= eff_base;
                  wb_q    <= eff_base + step_x;
                  wb_en_q <= 1'b1;
               end
               AM_DISP: begin
                  addr_q <= sum_inner;
               end
               AM_IDX_S, AM_IDX_F: begin
                  addr_q <= sum_full;
               end
               AM_MEM_PRE: begin
                  ptr_addr_q <= sum_full;
                  post_add_q <= outer_disp;
               end
               default: begin
                  ptr_addr_q <= sum_inner;
                  post_add_q <= idx_x + outer_disp;
               end
            endcase
         end else if (finish) begin
            addr_q <= ptr_data + post_add_q;
         end
      end
   end

   assign done     = done_q;
   assign addr_out = addr_q;
   assign wb_val   = wb_q;
   assign wb_en    = wb_en_q;
   assign ptr_req  = busy;
   assign ptr_addr = ptr_addr_q;

   p_ptr_stable_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      ptr_req && !ptr_ack |=> ptr_req && $stable(ptr_addr));
   p_wb_needs_done_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);
   p_mem_no_wb_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wb_en);
   p_addr_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && !ptr_ack |=> $stable(addr_out));

endmodule

// File: tb/opnd_addr_gen_bench.sv
module opnd_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        use_pc = 1'b0;
   logic        reg_is_sp = 1'b0;
   logic [31:0] base_reg = '0;
   logic [31:0] pc_val = '0;
   logic [31:0] idx_val = '0;
   logic [1:0]  idx_scale = 2'd0;
   logic [31:0] disp_in = '0;
   logic        disp_long = 1'b0;
   logic [31:0] outer_disp = '0;
   logic [1:0]  op_size = 2'd0;
   logic        busy, done, wb_en, ptr_req;
   logic [31:0] addr_out, wb_val, ptr_addr;
   logic        ptr_ack = 1'b0;
   logic [31:0] ptr_data = '0;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   opnd_addr_gen u_opnd_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .use_pc(use_pc),
      .reg_is_sp(reg_is_sp), .base_reg(base_reg), .pc_val(pc_val),
      .idx_val(idx_val), .idx_scale(idx_scale), .disp_in(disp_in),
      .disp_long(disp_long), .outer_disp(outer_disp), .op_size(op_size),
      .busy(busy), .done(done), .addr_out(addr_out), .wb_en(wb_en),
      .wb_val(wb_val), .ptr_req(ptr_req), .ptr_addr(ptr_addr),
      .ptr_ack(ptr_ack), .ptr_data(ptr_data)
   );

   typedef struct packed {
      logic [2:0]  md;
      logic        pcs;
      logic        sp;
      logic [31:0] base;
      logic [31:0] pc;
      logic [31:0] idx;
      logic [1:0]  sc;
      logic [31:0] dsp;
      logic        dl;
      logic [1:0]  sz;
      logic [31:0] e_addr;
      logic        e_wbe;
      logic [31:0] e_wb;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{3'd0,1'b0,1'b0,32'h1000,32'h0,32'h0,2'd0,32'h0,1'b0,2'd2,32'h1000,1'b0,32'h0},
      '{3'd0,1'b1,1'b0,32'h1000,32'h8000,32'h0,2'd0,32'h0,1'b0,2'd2,32'h1000,1'b0,32'h0},
      '{3'd3,1'b0,1'b0,32'h1000,32'h0,32'h0,2'd0,32'hFFF0,1'b0,2'd2,32'h0FF0,1'b0,32'h0},
      '{3'd3,1'b1,1'b0,32'h1000,32'h8000,32'h0,2'd0,32'h0010,1'b0,2'd2,32'h8010,1'b0,32'h0},
      '{3'd4,1'b0,1'b0,32'h2000,32'h0,32'h10,2'd2,32'h80,1'b0,2'd2,32'h1FC0,1'b0,32'h0},
      '{3'd4,1'b0,1'b0,32'h100,32'h0,32'h3,2'd3,32'h1234,1'b0,2'd2,32'h14C,1'b0,32'h0},
      '{3'd5,1'b0,1'b0,32'h10,32'h0,32'h1,2'd0,32'h12345,1'b1,2'd2,32'h12356,1'b0,32'h0},
      '{3'd5,1'b0,1'b0,32'h10000,32'h0,32'h0,2'd0,32'h18000,1'b0,2'd2,32'h8000,1'b0,32'h0},
      '{3'd1,1'b0,1'b0,32'h100,32'h0,32'h0,2'd0,32'h0,1'b0,2'd2,32'hFC,1'b1,32'hFC},
      '{3'd1,1'b0,1'b0,32'h100,32'h0,32'h0,2'd0,32'h0,1'b0,2'd1,32'hFE,1'b1,32'hFE},
      '{3'd1,1'b0,1'b0,32'h100,32'h0,32'h0,2'd0,32'h0,1'b0,2'd0,32'hFF,1'b1,32'hFF},
      '{3'd1,1'b0,1'b1,32'h100,32'h0,32'h0,2'd0,32'h0,1'b0,2'd0,32'hFE,1'b1,32'hFE},
      '{3'd2,1'b1,1'b0,32'h100,32'h9000,32'h0,2'd0,32'h0,1'b0,2'd0,32'h100,1'b1,32'h101},
      '{3'd2,1'b0,1'b1,32'h100,32'h0,32'h0,2'd0,32'h0,1'b0,2'd0,32'h100,1'b1,32'h102},
      '{3'd2,1'b0,1'b0,32'hFFFFFFFE,32'h0,32'h0,2'd0,32'h0,1'b0,2'd2,32'hFFFFFFFE,1'b1,32'h2},
      '{3'd3,1'b0,1'b0,32'hFFFFFFF0,32'h0,32'h0,2'd0,32'h0020,1'b0,2'd2,32'h10,1'b0,32'h0},
      '{3'd5,1'b1,1'b0,32'h0,32'h4000,32'hFFFFFFFF,2'd1,32'h100,1'b1,2'd2,32'h40FE,1'b0,32'h0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_in(input logic [2:0] md, input logic pcs, input logic sp,
                         input logic [31:0] b, input logic [31:0] pc,
                         input logic [31:0] ix, input logic [1:0] sc,
                         input logic [31:0] d, input logic dl,
                         input logic [31:0] od, input logic [1:0] sz);
      mode = md; use_pc = pcs; reg_is_sp = sp; base_reg = b; pc_val = pc;
      idx_val = ix; idx_scale = sc; disp_in = d; disp_long = dl;
      outer_disp = od; op_size = sz;
   endtask

   // Runs a memory-indirect access with an acknowledge after 3 wait cycles.
   task automatic mem_run(input string tag, input logic [31:0] e_ptr,
                          input logic [31:0] data, input logic [31:0] e_addr,
                          input logic poke);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R11 busy after start"}, 32'(busy), 32'd1);
      chk({tag, " R11 ptr_req"}, 32'(ptr_req), 32'd1);
      chk({tag, " ptr_addr"}, ptr_addr, e_ptr);
      if (poke) begin
         set_in(3'd0, 1'b0, 1'b0, 32'hDEAD0000, 32'h0, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0, 2'd2);
         start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R11 no done while waiting"}, 32'(done), 32'd0);
      @(negedge clk);
      chk({tag, " R11 req held"}, 32'(ptr_req), 32'd1);
      chk({tag, " R11 ptr_addr stable"}, ptr_addr, e_ptr);
      ptr_ack = 1'b1;
      ptr_data = data;
      @(negedge clk);
      ptr_ack = 1'b0;
      chk({tag, " R11 done after ack"}, 32'(done), 32'd1);
      chk({tag, " R11 busy cleared"}, 32'(busy), 32'd0);
      chk({tag, " final addr"}, addr_out, e_addr);
      chk({tag, " R9 no writeback"}, 32'(wb_en), 32'd0);
      @(negedge clk);
      chk({tag, " R11 single done pulse"}, 32'(done), 32'd0);
      chk({tag, " R11 addr kept"}, addr_out, e_addr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("reset busy R11", 32'(busy), 32'd0);
      chk("reset done R1", 32'(done), 32'd0);
      chk("reset ptr_req R11", 32'(ptr_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R12
      for (int i = 0; i < NV; i++) begin
         set_in(TBL[i].md, TBL[i].pcs, TBL[i].sp, TBL[i].base, TBL[i].pc,
                TBL[i].idx, TBL[i].sc, TBL[i].dsp, TBL[i].dl, 32'h0, TBL[i].sz);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk($sformatf("vec%0d R1 done", i), 32'(done), 32'd1);
         chk($sformatf("vec%0d addr R2/R3/R4/R5/R12", i), addr_out, TBL[i].e_addr);
         chk($sformatf("vec%0d R6/R7 wb_en", i), 32'(wb_en), 32'(TBL[i].e_wbe));
         if (TBL[i].e_wbe)
            chk($sformatf("vec%0d R6/R7/R8 wb_val", i), wb_val, TBL[i].e_wb);
         @(negedge clk);
      end

      // R9: pre-indexed, pointer at 0x1000+0x20+4*4
      set_in(3'd6, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h4, 2'd2, 32'h20, 1'b1, 32'h8, 2'd2);
      mem_run("R9 pre", 32'h1030, 32'h5000, 32'h5008, 1'b0);

      // R10: post-indexed, index added after the fetch
      set_in(3'd7, 1'b0, 1'b0, 32'h1000, 32'h0, 32'h4, 2'd2, 32'h20, 1'b1, 32'h8, 2'd2);
      mem_run("R10 post", 32'h1020, 32'h5000, 32'h5018, 1'b0);

      // R5 + R10: pc base, short displacement; R11 start during busy ignored
      set_in(3'd7, 1'b1, 1'b0, 32'h1000, 32'h9000, 32'h1, 2'd0, 32'h10, 1'b0, 32'h0, 2'd2);
      mem_run("R5 R11 pc post", 32'h9010, 32'h7000, 32'h7001, 1'b1);

      // R12: pointer plus outer wraps
      set_in(3'd6, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 2'd0, 32'h40, 1'b0, 32'h20, 2'd2);
      mem_run("R12 wrap", 32'h40, 32'hFFFFFFF0, 32'h10, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule